// File: doc/BRIEF.md
# Tree-Structured Lookahead Adder

This block adds two unsigned operands of `WIDTH` bits (8 by default) and returns a result that is one bit wider. The top bit of the result is the carry-out. The block is purely combinational. It has no clock, no state and no carry-in.

The adder is a binary tree of lookahead stages. Each stage either splits into two half-width stages, or, at 2 bits, becomes a leaf. A leaf is two full-adder cells that ripple the carry between them. Every stage reports a group propagate and a group generate signal. A combining stage uses the lower half's group signals and its own carry-in to form the carry into the upper half. It then merges both halves into the group signals it passes to its parent. At the root the carry-in is zero, so the carry-out comes from the root group generate and not from a ripple chain. With the default width the tree has three levels: 8 bits split into two 4-bit stages, and each 4-bit stage splits into two 2-bit leaves.

Top module: `cla_add_tree`

## Requirements
- R1: For every pair of operands, `sum_out` equals the unsigned sum `a_in + b_in`, zero-extended to `WIDTH+1` bits.
- R2: Bit `WIDTH` of `sum_out` is the carry-out. For example, 0xFF + 0xFF gives 0x1FE and 0xFF + 0x00 gives 0x0FF. It can be 1 only when at least one operand has its top bit set.
- R3: Two zero operands give a result of 0.
- R4: A carry out of the lower 4-bit half reaches the upper half through lookahead: 0x0F + 0x01 gives 0x010.
- R5: A carry that crosses a 2-bit leaf boundary inside one half arrives correctly: 0x03 + 0x01 gives 0x004, and 0x30 + 0x10 gives 0x040.
- R6: A carry generated in bit 0 travels through every group propagate to the carry-out: 0xFF + 0x01 gives 0x100, and 0x01 + 0xFF gives 0x100.
- R7: Each stage's sum slice, extended with its lookahead carry-out (group generate OR (group propagate AND carry-in)), equals its operand slices plus its carry-in. Inside each leaf, the rippled carry out of the upper cell equals that lookahead carry.
- R8: Propagate is formed with XOR, so no stage ever has group propagate and group generate both set. Operands where every bit propagates (0x55 + 0xAA gives 0x0FF) and operands where every other bit generates (0xAA + 0xAA gives 0x154) still add correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First unsigned operand |
| b_in | input | WIDTH | Second unsigned operand |
| sum_out | output | WIDTH+1 | Unsigned sum; top bit is the carry-out |

## Verification
Every result is due in the same cycle as its operands, because the block holds no register and its latency is zero cycles. The bench drives each operand pair on a falling clock edge and pushes the expected sum into a queue. On the following rising edge, half a period later, it pops the entry and compares it against `sum_out`, so the tree has settled before the sample is taken. All 65,536 operand pairs are swept, and directed pairs aimed at leaf, half and full carry chains come first. The per-stage relation of R7 and the exclusivity of R8 are checked by assertions inside every stage, for every swept pair.

// File: rtl/cla_pkg.sv
// Shared group-signal type and the lookahead merge used by every combining
// stage of the adder tree. Assumes propagate is formed with XOR.
package cla_pkg;

    typedef struct packed {
        logic p;   // group propagate
        logic g;   // group generate
    } grp_t;

    // Merge a lower and an upper group into the parent group.
    function automatic grp_t grp_merge(input grp_t lo, input grp_t hi);
        grp_t r;
        r.p = hi.p & lo.p;
        r.g = hi.g | (hi.p & lo.g);
        return r;
    endfunction

    // Carry out of a group, given its carry-in.
    function automatic logic grp_carry(input grp_t gr, input logic cin);
        return gr.g | (gr.p & cin);
    endfunction

endpackage

// File: rtl/cla_fa_cell.sv
// Single-bit full adder: sum is the parity of the three inputs and the carry
// is their majority. Purely combinational.
module cla_fa_cell (
    input  logic a,
    input  logic b,
    input  logic cin,
    output logic s,
    output logic cout
);

    // Parity sum and majority carry.
    always_comb begin
        s    = a ^ b ^ cin;
        cout = (a & b) | (b & cin) | (a & cin);
    end

endmodule

// File: rtl/cla_node.sv
// One stage of the lookahead tree. At W == 2 it is a leaf: two full-adder
// cells rippling the carry, with group signals formed by lookahead. Above 2 it
// splits into two W/2 stages and forms the upper-half carry-in by lookahead.
// Assumes W is a power of two and at least 2.
module cla_node #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         grp_p,
    output logic         grp_g
);
    import cla_pkg::*;

    localparam int H = W / 2;

    grp_t grp;
    assign grp_p = grp.p;
    assign grp_g = grp.g;

    generate
        if (W == 2) begin : g_leaf
            logic       c_mid;
            logic       c_rip;
            logic [1:0] bp;
            logic [1:0] bg;

            cla_fa_cell u_fa0 (.a(a[0]), .b(b[0]), .cin(cin),   .s(sum[0]), .cout(c_mid));
            cla_fa_cell u_fa1 (.a(a[1]), .b(b[1]), .cin(c_mid), .s(sum[1]), .cout(c_rip));

            // Bit-level propagate/generate and the leaf's lookahead group.
            always_comb begin
                bp    = a ^ b;
                bg    = a & b;
                grp.p = bp[1] & bp[0];
                grp.g = bg[1] | (bp[1] & bg[0]);
            end

            // R7: the rippled carry must match the lookahead carry-out.
            always_comb begin
                a_r7_ripple_vs_lookahead: assert (c_rip == grp_carry(grp, cin))
                    else $error("leaf ripple carry disagrees with lookahead");
            end
        end else begin : g_split
            grp_t lo_grp;
            grp_t hi_grp;
            logic c_hi;

            cla_node #(.W(H)) u_lo (
                .a(a[H-1:0]), .b(b[H-1:0]), .cin(cin),
                .sum(sum[H-1:0]), .grp_p(lo_grp.p), .grp_g(lo_grp.g)
            );

            cla_node #(.W(H)) u_hi (
                .a(a[W-1:H]), .b(b[W-1:H]), .cin(c_hi),
                .sum(sum[W-1:H]), .grp_p(hi_grp.p), .grp_g(hi_grp.g)
            );

            // Lookahead carry into the upper half and the merged group.
            always_comb begin
                c_hi = grp_carry(lo_grp, cin);
                grp  = grp_merge(lo_grp, hi_grp);
            end
        end
    endgenerate

    // R7: the slice sum plus lookahead carry equals the slice operands plus cin.
    always_comb begin
        a_r7_slice_sum: assert ({grp_carry(grp, cin), sum} ==
                                ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
            else $error("stage sum disagrees with its operands");
    end

    // R8: with XOR propagate, group propagate and generate are exclusive.
    always_comb begin
        a_r8_pg_exclusive: assert (!(grp.p && grp.g))
            else $error("group propagate and generate both set");
    end

endmodule

// File: rtl/cla_add_tree.sv
// Top of the tree-structured lookahead adder: unsigned WIDTH-bit operands,
// WIDTH+1-bit result. There is no carry-in; the root stage sees zero, and the
// carry-out comes from the root group generate. Assumes WIDTH is a power of
// two and at least 4. Purely combinational.
module cla_add_tree #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH:0]   sum_out
);
    import cla_pkg::*;

    logic [WIDTH-1:0] root_sum;
    grp_t             root_grp;

    cla_node #(.W(WIDTH)) u_root (
        .a(a_in), .b(b_in), .cin(1'b0),
        .sum(root_sum), .grp_p(root_grp.p), .grp_g(root_grp.g)
    );

    // Result: the root slice with the lookahead carry-out on top.
    always_comb begin
        sum_out = {grp_carry(root_grp, 1'b0), root_sum};
    end

    // R1: the full result equals the unsigned operand sum.
    always_comb begin
        a_r1_full_sum: assert (sum_out == ({1'b0, a_in} + {1'b0, b_in}))
            else $error("adder result wrong");
    end

    // R2: a carry-out needs at least one operand MSB set.
    always_comb begin
        a_r2_carry_needs_msb: assert (!sum_out[WIDTH] || a_in[WIDTH-1] || b_in[WIDTH-1])
            else $error("carry-out without an operand MSB");
    end

endmodule

// File: tb/cla_add_tree_test.sv
// Scoreboard bench: a driver pushes expected sums, a monitor pops and compares.
module cla_add_tree_test;

    localparam int  WIDTH    = 8;
    localparam time CLK_PER  = 10ns;
    localparam int  WDOG_MAX = 200000;

    typedef struct {
        logic [WIDTH-1:0] a;
        logic [WIDTH-1:0] b;
        logic [WIDTH:0]   exp;
        string            tag;
    } item_t;

    logic             clk = 1'b0;
    logic [WIDTH-1:0] a_in = '0;
    logic [WIDTH-1:0] b_in = '0;
    logic [WIDTH:0]   sum_out;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    drv_done = 1'b0;

    cla_add_tree #(.WIDTH(WIDTH)) uut (.a_in(a_in), .b_in(b_in), .sum_out(sum_out));

    always #(CLK_PER / 2) clk = ~clk;

    // Driver: apply operands on the falling edge and record the expected sum.
    task automatic drive(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                         input logic [WIDTH:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        a_in = a;
        b_in = b;
        it.a = a; it.b = b; it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: half a period after the driver, compare the output.
    always @(posedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (sum_out !== it.exp) begin
                errors++;
                $display("FAIL %s: %h + %h got %h expected %h",
                         it.tag, it.a, it.b, sum_out, it.exp);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG_MAX) begin
            errors++;
            $display("FAIL watchdog: cycles %0d expected below %0d", cycles, WDOG_MAX);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        drive(8'h00, 8'h00, 9'h000, "R3");
        drive(8'hFF, 8'hFF, 9'h1FE, "R2");
        drive(8'hFF, 8'h00, 9'h0FF, "R2");
        drive(8'h0F, 8'h01, 9'h010, "R4");
        drive(8'h03, 8'h01, 9'h004, "R5");
        drive(8'h30, 8'h10, 9'h040, "R5");
        drive(8'hFF, 8'h01, 9'h100, "R6");
        drive(8'h01, 8'hFF, 9'h100, "R6");
        drive(8'h55, 8'hAA, 9'h0FF, "R8");
        drive(8'hAA, 8'hAA, 9'h154, "R8");
        drive(8'h80, 8'h80, 9'h100, "R2");
        drive(8'h7F, 8'h7F, 9'h0FE, "R7");
        // Exhaustive sweep: R1, with R7/R8 assertions active in every stage.
        for (int i = 0; i < (1 << (2 * WIDTH)); i++) begin
            logic [WIDTH-1:0] ea;
            logic [WIDTH-1:0] eb;
            ea = i[2*WIDTH-1:WIDTH];
            eb = i[WIDTH-1:0];
            drive(ea, eb, {1'b0, ea} + {1'b0, eb}, "R1");
        end
        drv_done = 1'b1;
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule